// File: doc/BRIEF.md
# Packed-Element Vector Sequencer

This block turns a set-length request into an ordered stream of per-element operation slots. Elements narrower than the 32-bit container are packed into each register, so one register may hold several elements. Each architectural register has a small configuration entry with two fields: an element-width code and a vector length counted in whole registers. A set-length request names a base register and a requested length. The block multiplies the stored register count by the number of elements per register. It clamps the result against a depth limit and against the request, and reports the resulting active length.

The block then walks element indices 0 up to one less than the active length and issues one descriptor per accepted handshake. A descriptor gives the physical register, the bit offset of the lane, the element width, the element index and a flag for the final element. The lower lane of a register is always used before the upper lanes. The walk ends with a completion pulse. Reserved width codes, a zero length and a walk that runs past the last register all end early, each in its own defined way.

Top module: `simd_elem_seq`

## Requirements
- R1: Width code 3'b000 and 3'b011 select 32-bit elements (1 per register), 3'b001 selects 8-bit elements (4 per register) and 3'b010 selects 16-bit elements (2 per register).
- R2: Width codes 3'b100 to 3'b111 are illegal. A request on a register holding such a code issues no element. In the cycle after acceptance, cfg_illegal and seq_done are both high for one cycle and act_len reads 0.
- R3: In the cycle after a request is accepted, act_len equals min(min(stored length × elements per register, MAX_DEPTH), req_len). It holds that value until the next acceptance.
- R4: Element index i is issued with el_reg = base + i / n and el_lane = (i mod n) × width, where n is the number of elements per register. el_width carries the width and el_idx carries i.
- R5: Exactly act_len elements are issued, in ascending index order. el_last is high only on the element with index act_len−1.
- R6: While el_valid is high and el_ready is low, the descriptor holds steady. When el_ready is high, one element is accepted per clock.
- R7: seq_done pulses for one cycle in the cycle after the final handshake. A request that yields an active length of zero raises seq_done in the cycle after acceptance and issues nothing.
- R8: If the next element would fall in a register above 31, that element is not issued. range_err and seq_done then pulse together one cycle later.
- R9: cfg_we writes the width code and stored length of entry cfg_reg. After reset, every entry holds code 3'b000 and length 0. After reset, req_ready is high, el_valid and seq_done are low, and act_len is 0. Requests are accepted only while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration entry write enable |
| cfg_reg | input | 5 | Entry written |
| cfg_wcode | input | 3 | Element-width code written |
| cfg_vlen | input | VL_W | Stored vector length in registers |
| req_valid | input | 1 | Set-length request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_reg | input | 5 | Base register of the request |
| req_len | input | LEN_W | Requested element count |
| act_len | output | CNT_W | Clamped active length |
| cfg_illegal | output | 1 | Illegal width code pulse |
| el_valid | output | 1 | Element descriptor valid |
| el_ready | input | 1 | Element descriptor accepted |
| el_reg | output | 5 | Physical register of the element |
| el_lane | output | 5 | Lowest bit of the element lane |
| el_width | output | 6 | Element width in bits |
| el_idx | output | CNT_W | Element index |
| el_last | output | 1 | Final element of the sequence |
| seq_done | output | 1 | Sequence completion pulse |
| range_err | output | 1 | Register range overflow pulse |

## Verification
The bench uses the default parameters: MAX_DEPTH of 16, a 5-bit stored length and an 8-bit requested length. With these values, 8-bit elements exceed the depth limit once more than four registers are stored, so the depth clamp is reached often. Requested lengths up to 23 exceed the depth limit, so the request clamp is reached as well. Base registers from 28 to 31 are drawn often, so packed walks run past register 31 and exercise the range-error ending. Random back-pressure on el_ready exercises stalls in the middle of a register as well as at register boundaries.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;

  localparam int ELEN   = 32;
  localparam int NREG   = 32;
  localparam int REG_W  = 5;
  localparam int CODE_W = 3;
  localparam int WID_W  = 6;
  localparam int LANE_W = 5;

  typedef struct packed {
    logic             legal;
    logic [WID_W-1:0] width;
    logic [1:0]       shift;   // log2 of elements per register
  } wdec_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_st_t;

  function automatic wdec_t decode_wcode(input logic [CODE_W-1:0] c);
    wdec_t d;
    d.legal = 1'b1;
    d.width = WID_W'(ELEN);
    d.shift = 2'd0;
    case (c)
      3'b000, 3'b011: begin d.width = WID_W'(32); d.shift = 2'd0; end
      3'b001:         begin d.width = WID_W'(8);  d.shift = 2'd2; end
      3'b010:         begin d.width = WID_W'(16); d.shift = 2'd1; end
      default:        d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/simd_csr_bank.sv
module simd_csr_bank
  import simd_seq_pkg::*;
#(
  parameter int VL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [VL_W-1:0]   wr_vlen,
  input  logic [REG_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [VL_W-1:0]   rd_vlen
);

  logic [CODE_W-1:0] code_arr [NREG];
  logic [VL_W-1:0]   vlen_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic              hit;
    logic [CODE_W-1:0] code_r;
    logic [VL_W-1:0]   vlen_r;

    assign hit = wr_en && (wr_idx == REG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_r <= '0;
        vlen_r <= '0;
      end else if (hit) begin
        code_r <= wr_code;
        vlen_r <= wr_vlen;
      end
    end

    assign code_arr[g] = code_r;
    assign vlen_arr[g] = vlen_r;
  end

  assign rd_code = code_arr[rd_idx];
  assign rd_vlen = vlen_arr[rd_idx];

endmodule

// File: rtl/simd_len_calc.sv
module simd_len_calc
  import simd_seq_pkg::*;
#(
  parameter int VL_W      = 5,
  parameter int LEN_W     = 8,
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [VL_W-1:0]   csr_vlen,
  input  logic [LEN_W-1:0]  req_len,
  output logic              legal,
  output logic [WID_W-1:0]  width,
  output logic [1:0]        shift,
  output logic [CNT_W-1:0]  act_len
);

  wdec_t       dec;
  logic [31:0] vlen_el;
  logic [31:0] cap_depth;
  logic [31:0] cap_req;

  always_comb begin
    dec       = decode_wcode(code);
    vlen_el   = 32'(csr_vlen) << dec.shift;
    cap_depth = (vlen_el < 32'(MAX_DEPTH)) ? vlen_el : 32'(MAX_DEPTH);
    cap_req   = (cap_depth < 32'(req_len)) ? cap_depth : 32'(req_len);
  end

  assign legal   = dec.legal;
  assign width   = dec.width;
  assign shift   = dec.shift;
  assign act_len = dec.legal ? CNT_W'(cap_req) : '0;

endmodule

// File: rtl/simd_elem_walk.sv
module simd_elem_walk
  import simd_seq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_legal,
  input  logic [CNT_W-1:0]  start_len,
  input  logic [REG_W-1:0]  start_base,
  input  logic [WID_W-1:0]  start_width,
  input  logic [1:0]        start_shift,
  input  logic              el_ready,
  output logic              idle,
  output logic [CNT_W-1:0]  act_len,
  output logic              el_valid,
  output logic [REG_W-1:0]  el_reg,
  output logic [LANE_W-1:0] el_lane,
  output logic [WID_W-1:0]  el_width,
  output logic [CNT_W-1:0]  el_idx,
  output logic              el_last,
  output logic              done,
  output logic              range_err,
  output logic              illegal
);

  localparam int RW = ((CNT_W > REG_W) ? CNT_W : REG_W) + 1;

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [REG_W-1:0] base_q, base_d;
  logic [WID_W-1:0] wid_q, wid_d;
  logic [1:0]       shf_q, shf_d;
  logic             done_q, done_d;
  logic             rerr_q, rerr_d;
  logic             ill_q, ill_d;
  logic             cfg_en;

  logic [RW-1:0]    reg_full;
  logic [1:0]       sub;
  logic [1:0]       sub_mask;
  logic [7:0]       lane_full;
  logic             ovf;
  logic             last_el;

  // element address generation
  always_comb begin
    reg_full  = RW'(base_q) + RW'(idx_q >> shf_q);
    sub_mask  = (shf_q == 2'd0) ? 2'b00 : (shf_q == 2'd1) ? 2'b01 : 2'b11;
    sub       = idx_q[1:0] & sub_mask;
    lane_full = 8'(sub) * 8'(wid_q);
    ovf       = (reg_full > RW'(NREG - 1));
    last_el   = ((CNT_W+1)'(idx_q) + (CNT_W+1)'(1)) == (CNT_W+1)'(len_q);
  end

  // next state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    len_d  = len_q;
    base_d = base_q;
    wid_d  = wid_q;
    shf_d  = shf_q;
    done_d = 1'b0;
    rerr_d = 1'b0;
    ill_d  = 1'b0;
    cfg_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cfg_en = 1'b1;
          len_d  = start_legal ? start_len : '0;
          base_d = start_base;
          wid_d  = start_width;
          shf_d  = start_shift;
          idx_d  = '0;
          ill_d  = !start_legal;
          if (!start_legal || (start_len == '0)) done_d = 1'b1;
          else                                   st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (ovf) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          rerr_d = 1'b1;
        end else if (el_ready) begin
          if (last_el) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + CNT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      rerr_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      rerr_q <= rerr_d;
      ill_q  <= ill_d;
    end
  end

  // request context, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
      wid_q  <= WID_W'(ELEN);
      shf_q  <= 2'd0;
    end else if (cfg_en) begin
      len_q  <= len_d;
      base_q <= base_d;
      wid_q  <= wid_d;
      shf_q  <= shf_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign act_len   = len_q;
  assign el_valid  = (st_q == ST_RUN) && !ovf;
  assign el_reg    = reg_full[REG_W-1:0];
  assign el_lane   = lane_full[LANE_W-1:0];
  assign el_width  = wid_q;
  assign el_idx    = idx_q;
  assign el_last   = (st_q == ST_RUN) && last_el;
  assign done      = done_q;
  assign range_err = rerr_q;
  assign illegal   = ill_q;

endmodule

// File: rtl/simd_elem_seq.sv
module simd_elem_seq
  import simd_seq_pkg::*;
#(
  parameter  int VL_W      = 5,
  parameter  int LEN_W     = 8,
  parameter  int MAX_DEPTH = 16,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_reg,
  input  logic [2:0]       cfg_wcode,
  input  logic [VL_W-1:0]  cfg_vlen,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [4:0]       req_reg,
  input  logic [LEN_W-1:0] req_len,
  output logic [CNT_W-1:0] act_len,
  output logic             cfg_illegal,
  output logic             el_valid,
  input  logic             el_ready,
  output logic [4:0]       el_reg,
  output logic [4:0]       el_lane,
  output logic [5:0]       el_width,
  output logic [CNT_W-1:0] el_idx,
  output logic             el_last,
  output logic             seq_done,
  output logic             range_err
);

  logic [CODE_W-1:0] rd_code;
  logic [VL_W-1:0]   rd_vlen;
  logic              c_legal;
  logic [WID_W-1:0]  c_width;
  logic [1:0]        c_shift;
  logic [CNT_W-1:0]  c_len;
  logic              idle;
  logic              start;

  assign start     = req_valid && idle;
  assign req_ready = idle;

  simd_csr_bank #(.VL_W(VL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_reg),
    .wr_code (cfg_wcode),
    .wr_vlen (cfg_vlen),
    .rd_idx  (req_reg),
    .rd_code (rd_code),
    .rd_vlen (rd_vlen)
  );

  simd_len_calc #(
    .VL_W(VL_W), .LEN_W(LEN_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)
  ) u_len (
    .code     (rd_code),
    .csr_vlen (rd_vlen),
    .req_len  (req_len),
    .legal    (c_legal),
    .width    (c_width),
    .shift    (c_shift),
    .act_len  (c_len)
  );

  simd_elem_walk #(.CNT_W(CNT_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_legal (c_legal),
    .start_len   (c_len),
    .start_base  (req_reg),
    .start_width (c_width),
    .start_shift (c_shift),
    .el_ready    (el_ready),
    .idle        (idle),
    .act_len     (act_len),
    .el_valid    (el_valid),
    .el_reg      (el_reg),
    .el_lane     (el_lane),
    .el_width    (el_width),
    .el_idx      (el_idx),
    .el_last     (el_last),
    .done        (seq_done),
    .range_err   (range_err),
    .illegal     (cfg_illegal)
  );

endmodule

// File: rtl/simd_seq_checker.sv
module simd_seq_checker #(
  parameter int MAX_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [CNT_W-1:0] act_len,
  input logic             cfg_illegal,
  input logic             el_valid,
  input logic             el_ready,
  input logic [4:0]       el_reg,
  input logic [4:0]       el_lane,
  input logic [5:0]       el_width,
  input logic             el_last,
  input logic             seq_done,
  input logic             range_err
);

  AST_DEPTH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_len) <= MAX_DEPTH); // R3

  AST_LANE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> (7'(el_lane) + 7'(el_width) <= 7'd32)); // R4

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && el_ready && el_last) |=> (seq_done && req_ready)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && !el_ready) |=> (el_valid && $stable(el_reg) && $stable(el_lane) && $stable(el_last))); // R6

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (seq_done && !el_valid && act_len == '0)); // R2

  AST_RANGE_END: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (seq_done && !el_valid && req_ready)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !el_valid); // R9

endmodule

bind simd_elem_seq simd_seq_checker #(.MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .act_len     (act_len),
  .cfg_illegal (cfg_illegal),
  .el_valid    (el_valid),
  .el_ready    (el_ready),
  .el_reg      (el_reg),
  .el_lane     (el_lane),
  .el_width    (el_width),
  .el_last     (el_last),
  .seq_done    (seq_done),
  .range_err   (range_err)
);

// File: tb/test_simd_elem_seq.sv
module test_simd_elem_seq;

  localparam int CLK_PERIOD = 10;
  localparam int VL_W       = 5;
  localparam int LEN_W      = 8;
  localparam int MAX_DEPTH  = 16;
  localparam int CNT_W      = $clog2(MAX_DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [4:0]       cfg_reg;
  logic [2:0]       cfg_wcode;
  logic [VL_W-1:0]  cfg_vlen;
  logic             req_valid;
  logic             req_ready;
  logic [4:0]       req_reg;
  logic [LEN_W-1:0] req_len;
  logic [CNT_W-1:0] act_len;
  logic             cfg_illegal;
  logic             el_valid;
  logic             el_ready;
  logic [4:0]       el_reg;
  logic [4:0]       el_lane;
  logic [5:0]       el_width;
  logic [CNT_W-1:0] el_idx;
  logic             el_last;
  logic             seq_done;
  logic             range_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int m_code [32];
  int m_vlen [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_elem_seq #(.VL_W(VL_W), .LEN_W(LEN_W), .MAX_DEPTH(MAX_DEPTH)) i_simd_elem_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_wcode(cfg_wcode),
    .cfg_vlen(cfg_vlen), .req_valid(req_valid), .req_ready(req_ready), .req_reg(req_reg),
    .req_len(req_len), .act_len(act_len), .cfg_illegal(cfg_illegal), .el_valid(el_valid),
    .el_ready(el_ready), .el_reg(el_reg), .el_lane(el_lane), .el_width(el_width),
    .el_idx(el_idx), .el_last(el_last), .seq_done(seq_done), .range_err(range_err)
  );

  task automatic report();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit m_legal(input int c); return c < 4; endfunction
  function automatic int m_width(input int c);
    return (c == 1) ? 8 : (c == 2) ? 16 : 32;
  endfunction
  function automatic int m_shift(input int c);
    return (c == 1) ? 2 : (c == 2) ? 1 : 0;
  endfunction
  function automatic int m_act(input int c, input int vl, input int len);
    int v;
    if (!m_legal(c)) return 0;
    v = vl << m_shift(c);
    if (v > MAX_DEPTH) v = MAX_DEPTH;
    if (v > len) v = len;
    return v;
  endfunction

  task automatic write_cfg(input int r, input int c, input int vl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = 5'(r); cfg_wcode = 3'(c); cfg_vlen = VL_W'(vl);
    @(negedge clk);
    cfg_we = 1'b0;
    m_code[r] = c; m_vlen[r] = vl;
  endtask

  task automatic run_req(input int r, input int len, input bit rnd_ready);
    int c, act, shf, wd, cap, exp_n, k, guard, held_idx;
    bit exp_rerr, stalled;
    c     = m_code[r];
    act   = m_act(c, m_vlen[r], len);
    shf   = m_shift(c);
    wd    = m_width(c);
    cap   = (32 - r) << shf;
    exp_n = (act < cap) ? act : cap;
    exp_rerr = (exp_n < act);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_reg = 5'(r); req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(int'(act_len) == act, "R3 act_len", int'(act_len), act);
    if (!m_legal(c)) begin
      chk(cfg_illegal && seq_done && !el_valid, "R2 illegal code ends quietly",
          int'({cfg_illegal, seq_done, el_valid}), 6);
      return;
    end
    chk(!cfg_illegal, "R1 legal code not flagged", int'(cfg_illegal), 0);
    if (act == 0) begin
      chk(seq_done && !el_valid, "R7 zero length done", int'({seq_done, el_valid}), 2);
      return;
    end
    k = 0; guard = 0; stalled = 1'b0; held_idx = 0;
    while (!seq_done && guard < 400) begin
      el_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      if (el_valid) begin
        if (stalled) chk(int'(el_idx) == held_idx, "R6 stalled descriptor held", int'(el_idx), held_idx);
        chk(int'(el_idx) == k, "R5 ascending index", int'(el_idx), k);
        chk(int'(el_reg) == r + (k >> shf), "R4 element register", int'(el_reg), r + (k >> shf));
        chk(int'(el_lane) == (k & ((1 << shf) - 1)) * wd, "R4 lane offset",
            int'(el_lane), (k & ((1 << shf) - 1)) * wd);
        chk(int'(el_width) == wd, "R1 element width", int'(el_width), wd);
        chk(el_last == (k == act - 1), "R5 last flag", int'(el_last), int'(k == act - 1));
        stalled  = !el_ready;
        held_idx = k;
        if (el_ready) k++;
      end
      @(negedge clk);
      guard++;
    end
    el_ready = 1'b0;
    chk(seq_done == 1'b1, "R7 done pulse", int'(seq_done), 1);
    chk(k == exp_n, "R5 element count", k, exp_n);
    chk(range_err == exp_rerr, "R8 range error", int'(range_err), int'(exp_rerr));
    @(negedge clk);
    chk(seq_done == 1'b0, "R7 done lasts one cycle", int'(seq_done), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin m_code[i] = 0; m_vlen[i] = 0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_reg = '0; cfg_wcode = '0; cfg_vlen = '0;
    req_valid = 1'b0; req_reg = '0; req_len = '0; el_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !el_valid && !seq_done && act_len == '0, "R9 reset state",
        int'({req_ready, el_valid, seq_done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset entries give zero length
    run_req(7, 5, 1'b0);
    // R4: 16-bit, three registers, five elements
    write_cfg(2, 3'b010, 3);
    run_req(2, 5, 1'b0);
    run_req(2, 5, 1'b1);
    // R3: depth clamp with 8-bit elements
    write_cfg(4, 3'b001, 8);
    run_req(4, 30, 1'b1);
    // R7: zero requested length
    run_req(4, 0, 1'b0);
    // R8: walk past register 31
    write_cfg(30, 3'b011, 5);
    run_req(30, 5, 1'b0);
    write_cfg(31, 3'b001, 3);
    run_req(31, 12, 1'b1);
    // R2: reserved codes
    write_cfg(9, 3'b110, 4);
    run_req(9, 4, 1'b0);
    write_cfg(10, 3'b101, 2);
    run_req(10, 3, 1'b0);
    // R1: default full width
    write_cfg(11, 3'b000, 2);
    run_req(11, 9, 1'b1);
    for (int it = 0; it < 80; it++) begin
      int r, c, vl;
      r  = ($urandom % 4 == 0) ? 28 + int'($urandom % 4) : int'($urandom % 32);
      c  = ($urandom % 6 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 4);
      vl = int'($urandom % 32);
      write_cfg(r, c, vl);
      run_req(r, int'($urandom % 24), 1'b1);
    end
    report();
  end

endmodule